// File: doc/BRIEF.md
# Masked Set/Clear Transmitter Control Register

This block is a register slice on a 16-bit-address, 16-bit-data register bus. It owns one 16-bit control word for a serial display transmitter. Software cannot write that word directly. Instead it sends a 32-bit command, as two 16-bit bus writes, to a write-only command location. The command carries a 3-bit operation code, a 5-bit target selector and a 16-bit bit mask. A set command ORs the mask into the control word. A clear command removes the masked bits from it.

The lower half of the command, which is the mask, is written first and is held in a staging register. The command acts only when its upper half is written; that half carries the operation code and the target selector. The control word can always be read back at its own address. Its fields drive five decoded outputs: display-mode enable, high-speed transmit, continuous clock, lane count and end-of-transmission packet disable. Reads are single-cycle requests. The data returns on the next cycle, marked by a valid pulse. There is no back-pressure: a read request is always accepted.

Top module: `dsi_ctl_setclr`

## Requirements
- R1: After reset the control word reads 0x8000. dsi_mode_en is 0, hs_tx, cont_clk and eot_dis are 0, and lane_cnt is 1.
- R2: A write to 0x502 with wdata[15:13]=5 and wdata[12:8]=3 ORs the staged mask into the control word. The new value is visible on the outputs and on readback from the next cycle.
- R3: A write to 0x502 with wdata[15:13]=6 and wdata[12:8]=3 clears every control bit that is set in the staged mask and leaves the other bits as they were.
- R4: A write to 0x502 with any other operation code, or with any target selector other than 3, leaves the control word unchanged.
- R5: A write to 0x500 only loads the 16-bit staging mask and does not change the control word. The most recent such write is the mask that the next command uses.
- R6: Bus writes to the control word's own addresses, 0x40C and 0x40E, are ignored.
- R7: Reads of 0x500, 0x502 and 0x40E, and reads of any unmapped address, return 0. A read of 0x40C returns the control word.
- R8: The decoded outputs follow the control word. dsi_mode_en is the inverse of bit 15, hs_tx is bit 7, cont_clk is bit 5, eot_dis is bit 0, and lane_cnt is bits 2:1 plus one.
- R9: rd_valid is high in the cycle after each cycle in which bus_rd is high, and only then. rd_data holds the value that was selected in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_addr | input | 16 | Byte address of the 16-bit half being accessed |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | rd_data is valid in this cycle |
| dsi_mode_en | output | 1 | Display-mode enable (inverse of control bit 15) |
| hs_tx | output | 1 | High-speed transmit mode (control bit 7) |
| cont_clk | output | 1 | Continuous high-speed clock (control bit 5) |
| lane_cnt | output | 3 | Number of active data lanes, 1 to 4 |
| eot_dis | output | 1 | End-of-transmission packet disable (control bit 0) |

## Verification
The bench builds the block with its default parameters: 16-bit data, the command at 0x500 and the control word at 0x40C. This configuration is small enough that every one of the 256 combinations of operation code and target selector is sent. Each combination uses its own computed mask, and the bench model reads the control word back after every command. The bench also writes a mask on its own, writes the control word directly, and reads the write-only and unmapped addresses.

// File: rtl/dsi_ctl_pkg.sv
package dsi_ctl_pkg;
  localparam int OP_W   = 3;
  localparam int TGT_W  = 5;
  localparam logic [OP_W-1:0]  OP_SET  = 3'd5;
  localparam logic [OP_W-1:0]  OP_CLR  = 3'd6;
  localparam logic [TGT_W-1:0] TGT_CTL = 5'd3;
  localparam int BIT_DSI_DIS = 15;
  localparam int BIT_HS_TX   = 7;
  localparam int BIT_CONT    = 5;
  localparam int BIT_EOT_DIS = 0;
  localparam int LANE_LO     = 1;
  localparam int LANE_W      = 2;
  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR} act_e;
endpackage

// File: rtl/dsi_cmd_stage.sv
module dsi_cmd_stage
  import dsi_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] stage_q,
  output act_e              act
);
  localparam logic [ADDR_W-1:0] CMD_HI = CMD_ADDR + ADDR_W'(2);
  localparam int OP_HI  = DATA_W - 1;
  localparam int TGT_HI = DATA_W - 1 - OP_W;

  logic [OP_W-1:0]  op;
  logic [TGT_W-1:0] tgt;

  assign op  = bus_wdata[OP_HI -: OP_W];
  assign tgt = bus_wdata[TGT_HI -: TGT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else if (bus_wr && bus_addr == CMD_ADDR) stage_q <= bus_wdata;
  end

  always_comb begin
    act = ACT_NONE;
    if (bus_wr && bus_addr == CMD_HI && tgt == TGT_CTL) begin
      if (op == OP_SET)      act = ACT_SET;
      else if (op == OP_CLR) act = ACT_CLR;
    end
  end
endmodule

// File: rtl/dsi_ctl_word.sv
module dsi_ctl_word
  import dsi_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] ctl_q
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) ctl_q[b] <= RST_VAL[b];
      else if (mask[b]) begin
        if (act == ACT_SET)      ctl_q[b] <= 1'b1;
        else if (act == ACT_CLR) ctl_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsi_rd_mux.sv
module dsi_rd_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h040C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (bus_addr == CTL_ADDR) sel = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= sel;
    end
  end
endmodule

// File: rtl/dsi_ctl_setclr.sv
module dsi_ctl_setclr
  import dsi_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h0500,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h040C,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              dsi_mode_en,
  output logic              hs_tx,
  output logic              cont_clk,
  output logic [LANE_W:0]   lane_cnt,
  output logic              eot_dis
);
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] ctl_q;
  act_e              act;

  dsi_cmd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)) u_stage (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stage_q(stage_q), .act(act)
  );

  dsi_ctl_word #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_word (
    .clk(clk), .rst_n(rst_n), .act(act), .mask(stage_q), .ctl_q(ctl_q)
  );

  dsi_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .ctl_q(ctl_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign dsi_mode_en = ~ctl_q[BIT_DSI_DIS];
  assign hs_tx       = ctl_q[BIT_HS_TX];
  assign cont_clk    = ctl_q[BIT_CONT];
  assign eot_dis     = ctl_q[BIT_EOT_DIS];
  assign lane_cnt    = {1'b0, ctl_q[LANE_LO +: LANE_W]} + (LANE_W+1)'(1);
endmodule

// File: rtl/dsi_ctl_setclr_chk.sv
module dsi_ctl_setclr_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h0500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] stage_q,
  input logic [DATA_W-1:0] ctl_q
);
  localparam logic [ADDR_W-1:0] CMD_HI = CMD_ADDR + ADDR_W'(2);

  AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CMD_HI && bus_wdata[15:8] == 8'hA3)
    |=> ((ctl_q & $past(stage_q)) == $past(stage_q))); // R2

  AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CMD_HI && bus_wdata[15:8] == 8'hC3)
    |=> ((ctl_q & $past(stage_q)) == '0)); // R3

  AST_HOLD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == CMD_HI) |=> $stable(ctl_q)); // R5

  AST_BAD_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CMD_HI && bus_wdata[15:8] != 8'hA3 && bus_wdata[15:8] != 8'hC3)
    |=> $stable(ctl_q)); // R4

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid); // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid); // R9

  AST_CMD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == CMD_ADDR || bus_addr == CMD_HI)) |=> (rd_data == '0)); // R7
endmodule

bind dsi_ctl_setclr dsi_ctl_setclr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
  .stage_q(stage_q), .ctl_q(ctl_q)
);

// File: tb/dsi_ctl_setclr_tb_top.sv
module dsi_ctl_setclr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] rd_data;
  logic rd_valid, dsi_mode_en, hs_tx, cont_clk, eot_dis;
  logic [2:0] lane_cnt;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model;
  logic [15:0] mask_m;
  logic [15:0] got;
  logic        vgot;

  always #10 clk = ~clk;

  dsi_ctl_setclr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .dsi_mode_en(dsi_mode_en), .hs_tx(hs_tx), .cont_clk(cont_clk),
    .lane_cnt(lane_cnt), .eot_dis(eot_dis)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    got = rd_data; vgot = rd_valid;
  endtask

  task automatic check_outs(input string req);
    check(req, {15'd0, dsi_mode_en}, {15'd0, ~model[15]});
    check(req, {15'd0, hs_tx},       {15'd0, model[7]});
    check(req, {15'd0, cont_clk},    {15'd0, model[5]});
    check(req, {15'd0, eot_dis},     {15'd0, model[0]});
    check(req, {13'd0, lane_cnt},    {13'd0, 3'({1'b0, model[2:1]} + 3'd1)});
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model = 16'h8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(16'h040C); check("R1 reset value", got, 16'h8000);
    check("R9 valid after read", {15'd0, vgot}, 16'd1);
    @(negedge clk);
    check("R9 valid drops", {15'd0, rd_valid}, 16'd0);
    check_outs("R1 reset outputs");
    check("R1 lane_cnt", {13'd0, lane_cnt}, 16'd1);

    // Sweep every op code and target selector
    for (int op = 0; op < 8; op++) begin
      for (int tg = 0; tg < 32; tg++) begin
        mask_m = 16'((op * 32 + tg) * 16'h9E37 + 16'h1234);
        wr(16'h0500, mask_m);
        rd(16'h040C); check("R5 mask-only no effect", got, model);
        wr(16'h0502, {3'(op), 5'(tg), 8'h00});
        if (tg == 3 && op == 5) model = model | mask_m;
        else if (tg == 3 && op == 6) model = model & ~mask_m;
        check_outs((tg == 3 && (op == 5 || op == 6)) ? "R8 outputs R2 R3" : "R8 outputs R4");
        rd(16'h040C);
        check((tg == 3 && op == 5) ? "R2 set" : (tg == 3 && op == 6) ? "R3 clear" : "R4 ignored",
              got, model);
      end
    end

    // Lane count sweep
    for (int l = 0; l < 4; l++) begin
      wr(16'h0500, 16'h0006); wr(16'h0502, 16'hC300);
      wr(16'h0500, 16'(l << 1)); wr(16'h0502, 16'hA300);
      model = (model & ~16'h0006) | 16'(l << 1);
      check("R8 lane_cnt", {13'd0, lane_cnt}, 16'(l + 1));
    end

    // Last mask write wins
    wr(16'h0500, 16'h00FF); wr(16'h0500, 16'h8001); wr(16'h0502, 16'hC300);
    model = model & ~16'h8001;
    rd(16'h040C); check("R5 last mask", got, model);
    check("R8 mode enabled", {15'd0, dsi_mode_en}, 16'd1);

    // Direct writes ignored
    wr(16'h040C, ~model); wr(16'h040E, 16'hFFFF);
    rd(16'h040C); check("R6 direct write ignored", got, model);
    check_outs("R6 outputs");

    // Reads of zero locations
    rd(16'h0500); check("R7 cmd lo read", got, 16'h0000);
    rd(16'h0502); check("R7 cmd hi read", got, 16'h0000);
    rd(16'h040E); check("R7 ctl upper read", got, 16'h0000);
    rd(16'h0123); check("R7 unmapped read", got, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule